// File: doc/BRIEF.md
# Bit-Manipulation ALU with Registered Result

This block is the execute stage of a small command-processor microcontroller. Each cycle it can take one operation: a 4-bit opcode, a first source, a second source (or an immediate that replaces it), two 5-bit bit positions and the current value of the destination register. It computes the answer combinationally and registers it, so the result and its valid flag appear on the clock edge after the request. Fetch, decode, the register file and branching live outside the block.

The operations are bit manipulation and small arithmetic. Bit-clear, run-time set/clear of one bit, immediate set and clear of a bit, unsigned bitfield extract, bitfield insert that ORs into the old destination, highest-set-bit index, a compare that yields a bitfield code for branch-on-bit, rotate left, logical and arithmetic right shift, an 8x8 multiply, and unsigned minimum and maximum.

The output side is a two-state machine. State `ST_IDLE` means the result register holds nothing new. State `ST_VALID` means it holds the answer to the previous cycle's request. The transitions are:
- `ST_IDLE -> ST_VALID` on a request.
- `ST_VALID -> ST_VALID` on a back-to-back request.
- `ST_VALID -> ST_IDLE` when no request arrives.
- Every other cycle stays in `ST_IDLE`.

Top module: `bmalu_top`

## Requirements
- R1: After reset `out_valid` is 0 and `result` is 0.
- R2: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` high. `result` keeps its value through any cycle without `in_valid`.
- R3: Opcode 0 (bit-clear) gives `a & ~b`. Here `a` is `src1` and `b` is the second operand (see R13).
- R4: Opcode 1 (run-time bit write) copies `a` and sets bit `b[5:1]` to `b[0]`. All other bits of `a` are unchanged.
- R5: Opcode 2 sets bit `pos_lo` of `a`. Opcode 3 clears bit `pos_lo` of `a`.
- R6: Opcode 4 (extract) gives `(a >> pos_lo)` masked to `pos_hi-pos_lo+1` bits. If `pos_hi < pos_lo` it gives 0.
- R7: Opcode 5 (insert) gives `dst_old | ((a masked to pos_hi-pos_lo+1 bits) << pos_lo)`. The field in `dst_old` is not cleared first. If `pos_hi < pos_lo` it gives `dst_old` unchanged.
- R8: Opcode 6 gives the index of the highest set bit of `b`, or 0 when `b` is 0.
- R9: Opcode 7 (compare) gives 0x2c when `a > b` unsigned, 0x2b when `a == b`, and 0x1e otherwise.
- R10: Opcodes 8, 9 and 10 use `b[4:0]` as the amount. Opcode 8 rotates `a` left, opcode 9 shifts it right filling with zeros, and opcode 10 shifts it right copying the sign bit.
- R11: Opcode 11 gives `a[7:0] * b[7:0]` as a 16-bit product, zero-extended.
- R12: Opcode 12 gives the unsigned minimum of `a` and `b`. Opcode 13 gives the unsigned maximum.
- R13: When `use_imm` is 1, `imm` replaces `src2` as `b` and `src2` has no effect on the result.
- R14: Opcodes 14 and 15 give a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Opcode |
| src1 | input | 32 | First source `a` |
| src2 | input | 32 | Second source register value |
| use_imm | input | 1 | Select `imm` instead of `src2` |
| imm | input | 32 | Immediate second source |
| pos_lo | input | 5 | Bit position / field low end |
| pos_hi | input | 5 | Field high end |
| dst_old | input | 32 | Current destination value, used by insert |
| out_valid | output | 1 | Result valid, one cycle after request |
| result | output | 32 | Registered result |

## Verification
The assertions assume that reset is held low for at least one edge before the first request. They also assume that opcode, operands and `use_imm` are stable across the sampling edge whenever `in_valid` is high, because each property re-derives the second operand from the sampled ports. The bench changes every input only on the falling clock edge. It keeps reset low for several edges before it starts driving requests, so both conditions always hold.

// File: rtl/bmalu_pkg.sv
package bmalu_pkg;

    typedef enum logic [3:0] {
        OP_BIC    = 4'd0,
        OP_BSETR  = 4'd1,
        OP_BSETI  = 4'd2,
        OP_BCLRI  = 4'd3,
        OP_EXTR   = 4'd4,
        OP_INSR   = 4'd5,
        OP_MSB    = 4'd6,
        OP_CMP    = 4'd7,
        OP_ROTL   = 4'd8,
        OP_SHRL   = 4'd9,
        OP_SHRA   = 4'd10,
        OP_MUL8   = 4'd11,
        OP_MINU   = 4'd12,
        OP_MAXU   = 4'd13,
        OP_RSV14  = 4'd14,
        OP_RSV15  = 4'd15
    } bmalu_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } bmalu_st_e;

    localparam logic [7:0] CMP_GT = 8'h2c;
    localparam logic [7:0] CMP_EQ = 8'h2b;
    localparam logic [7:0] CMP_LT = 8'h1e;

endpackage

// File: rtl/bmalu_shift.sv
module bmalu_shift
    import bmalu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int POS_W = $clog2(DATA_W)
) (
    input  bmalu_op_e          op,
    input  logic [DATA_W-1:0]  a,
    input  logic [POS_W-1:0]   amt,
    output logic [DATA_W-1:0]  y
);

    logic [2*DATA_W-1:0] doubled;
    logic [DATA_W-1:0]   rot_res;
    logic [DATA_W-1:0]   lsr_res;
    logic [DATA_W-1:0]   asr_res;

    always_comb begin
        doubled = {a, a} << amt;
        rot_res = doubled[2*DATA_W-1:DATA_W];
        lsr_res = a >> amt;
        asr_res = DATA_W'($signed(a) >>> amt);
    end

    always_comb begin
        unique case (op)
            OP_ROTL: y = rot_res;
            OP_SHRL: y = lsr_res;
            OP_SHRA: y = asr_res;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/bmalu_bitops.sv
module bmalu_bitops
    import bmalu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int POS_W = $clog2(DATA_W)
) (
    input  bmalu_op_e          op,
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    input  logic [POS_W-1:0]   lo,
    input  logic [POS_W-1:0]   hi,
    input  logic [DATA_W-1:0]  dst_old,
    output logic [DATA_W-1:0]  y
);

    localparam logic [POS_W-1:0] TOP_POS = POS_W'(DATA_W - 1);

    logic [POS_W-1:0]  dyn_idx;
    logic              dyn_val;
    logic [DATA_W-1:0] dyn_onehot;
    logic [DATA_W-1:0] imm_onehot;
    logic              fld_empty;
    logic [POS_W-1:0]  fld_span;
    logic [DATA_W-1:0] fld_mask;
    logic [DATA_W-1:0] extr_res;
    logic [DATA_W-1:0] insr_res;
    logic [POS_W-1:0]  msb_idx;

    // run-time bit write operands
    always_comb begin
        dyn_idx    = b[POS_W:1];
        dyn_val    = b[0];
        dyn_onehot = DATA_W'(1) << dyn_idx;
        imm_onehot = DATA_W'(1) << lo;
    end

    // bitfield mask shared by extract and insert
    always_comb begin
        fld_empty = (hi < lo);
        fld_span  = hi - lo;
        fld_mask  = {DATA_W{1'b1}} >> (TOP_POS - fld_span);
        extr_res  = fld_empty ? '0 : ((a >> lo) & fld_mask);
        insr_res  = fld_empty ? dst_old : (dst_old | ((a & fld_mask) << lo));
    end

    // highest set bit, later (higher) bits override
    always_comb begin
        msb_idx = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (b[i]) msb_idx = POS_W'(i);
        end
    end

    always_comb begin
        unique case (op)
            OP_BIC:   y = a & ~b;
            OP_BSETR: y = dyn_val ? (a | dyn_onehot) : (a & ~dyn_onehot);
            OP_BSETI: y = a | imm_onehot;
            OP_BCLRI: y = a & ~imm_onehot;
            OP_EXTR:  y = extr_res;
            OP_INSR:  y = insr_res;
            OP_MSB:   y = DATA_W'(msb_idx);
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/bmalu_arith.sv
module bmalu_arith
    import bmalu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MUL_W  = 8
) (
    input  bmalu_op_e          op,
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    output logic [DATA_W-1:0]  y
);

    localparam int PROD_W = 2 * MUL_W;

    logic [PROD_W-1:0] prod;
    logic              a_gt;
    logic              a_eq;
    logic [7:0]        cmp_code;

    always_comb begin
        prod     = PROD_W'(a[MUL_W-1:0]) * PROD_W'(b[MUL_W-1:0]);
        a_gt     = (a > b);
        a_eq     = (a == b);
        cmp_code = a_gt ? CMP_GT : (a_eq ? CMP_EQ : CMP_LT);
    end

    always_comb begin
        unique case (op)
            OP_CMP:  y = DATA_W'(cmp_code);
            OP_MUL8: y = DATA_W'(prod);
            OP_MINU: y = a_gt ? b : a;
            OP_MAXU: y = a_gt ? a : b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/bmalu_top.sv
module bmalu_top
    import bmalu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MUL_W  = 8,
    localparam int POS_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] src1,
    input  logic [DATA_W-1:0] src2,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] imm,
    input  logic [POS_W-1:0]  pos_lo,
    input  logic [POS_W-1:0]  pos_hi,
    input  logic [DATA_W-1:0] dst_old,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);

    typedef enum logic [1:0] {
        U_BITS,
        U_SHIFT,
        U_ARITH,
        U_NONE
    } unit_e;

    bmalu_op_e         op_e;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] y_bits;
    logic [DATA_W-1:0] y_shift;
    logic [DATA_W-1:0] y_arith;
    unit_e             unit_sel;
    logic [DATA_W-1:0] next_res;
    bmalu_st_e         st_q;
    bmalu_st_e         st_d;
    logic [DATA_W-1:0] res_q;

    always_comb begin
        op_e   = bmalu_op_e'(op);
        opnd_b = use_imm ? imm : src2;
    end

    bmalu_bitops #(.DATA_W(DATA_W)) u_bits (
        .op      (op_e),
        .a       (src1),
        .b       (opnd_b),
        .lo      (pos_lo),
        .hi      (pos_hi),
        .dst_old (dst_old),
        .y       (y_bits)
    );

    bmalu_shift #(.DATA_W(DATA_W)) u_shift (
        .op  (op_e),
        .a   (src1),
        .amt (opnd_b[POS_W-1:0]),
        .y   (y_shift)
    );

    bmalu_arith #(.DATA_W(DATA_W), .MUL_W(MUL_W)) u_arith (
        .op (op_e),
        .a  (src1),
        .b  (opnd_b),
        .y  (y_arith)
    );

    // unit steering
    always_comb begin
        unique case (op_e)
            OP_BIC, OP_BSETR, OP_BSETI, OP_BCLRI,
            OP_EXTR, OP_INSR, OP_MSB:          unit_sel = U_BITS;
            OP_ROTL, OP_SHRL, OP_SHRA:         unit_sel = U_SHIFT;
            OP_CMP, OP_MUL8, OP_MINU, OP_MAXU: unit_sel = U_ARITH;
            default:                           unit_sel = U_NONE;
        endcase
    end

    always_comb begin
        unique case (unit_sel)
            U_BITS:  next_res = y_bits;
            U_SHIFT: next_res = y_shift;
            U_ARITH: next_res = y_arith;
            default: next_res = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        unique case (st_q)
            ST_IDLE:  st_d = in_valid ? ST_VALID : ST_IDLE;
            ST_VALID: st_d = in_valid ? ST_VALID : ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // result register
    always_ff @(posedge clk) begin
        if (!rst_n)        res_q <= '0;
        else if (in_valid) res_q <= next_res;
    end

    // outputs
    always_comb begin
        out_valid = (st_q == ST_VALID);
        result    = res_q;
    end

endmodule

// File: rtl/bmalu_chk.sv
module bmalu_chk #(
    parameter int DATA_W = 32,
    localparam int POS_W = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        op,
    input logic [DATA_W-1:0] src1,
    input logic [DATA_W-1:0] src2,
    input logic              use_imm,
    input logic [DATA_W-1:0] imm,
    input logic [POS_W-1:0]  pos_lo,
    input logic [POS_W-1:0]  pos_hi,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);

    logic [DATA_W-1:0] b_eff;
    assign b_eff = use_imm ? imm : src2;

    p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    p_bic_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd0) |=> ((result & $past(b_eff)) == '0));

    p_extract_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd4 && pos_hi < pos_lo) |=> (result == '0));

    p_msb_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd6) |=> (result < DATA_W));

    p_cmp_codes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd7) |=>
        (result == DATA_W'(8'h2c) || result == DATA_W'(8'h2b) || result == DATA_W'(8'h1e)));

    p_mul_width_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd11) |=> (result[DATA_W-1:16] == '0));

    p_min_le_max_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd12) |=> (result <= $past(src1) && result <= $past(b_eff)));

    p_reserved_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op >= 4'd14) |=> (result == '0));

endmodule

bind bmalu_top bmalu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .src1      (src1),
    .src2      (src2),
    .use_imm   (use_imm),
    .imm       (imm),
    .pos_lo    (pos_lo),
    .pos_hi    (pos_hi),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/tb_bmalu_top.sv
module tb_bmalu_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [3:0]  op;
    logic [31:0] src1, src2, imm, dst_old;
    logic        use_imm;
    logic [4:0]  pos_lo, pos_hi;
    logic        out_valid;
    logic [31:0] result;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bmalu_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src1(src1), .src2(src2), .use_imm(use_imm), .imm(imm),
        .pos_lo(pos_lo), .pos_hi(pos_hi), .dst_old(dst_old),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [31:0] ref_calc(input logic [3:0] o, input logic [31:0] a,
                                             input logic [31:0] b, input int lo, input int hi,
                                             input logic [31:0] d);
        logic [31:0]          r;
        longint unsigned      fld;
        int                   amt;
        r   = '0;
        amt = int'(b % 32);
        case (o)
            4'd0:  r = a & ~b;
            4'd1:  begin r = a; r[(b / 2) % 32] = b[0]; end
            4'd2:  begin r = a; r[lo] = 1'b1; end
            4'd3:  begin r = a; r[lo] = 1'b0; end
            4'd4:  begin
                       if (hi >= lo) begin
                           fld = (longint'(a) >> lo) % (64'd1 << (hi - lo + 1));
                           r = fld[31:0];
                       end
                   end
            4'd5:  begin
                       r = d;
                       if (hi >= lo) begin
                           fld = (longint'(a) % (64'd1 << (hi - lo + 1))) << lo;
                           r = d | fld[31:0];
                       end
                   end
            4'd6:  for (int i = 0; i < 32; i++) if (b[i]) r = i;
            4'd7:  r = (a > b) ? 32'h2c : ((a == b) ? 32'h2b : 32'h1e);
            4'd8:  r = (a << amt) | (a >> (32 - amt));
            4'd9:  r = a >> amt;
            4'd10: begin
                       r = a >> amt;
                       if (a[31]) for (int i = 0; i < amt; i++) r[31 - i] = 1'b1;
                   end
            4'd11: r = (a % 256) * (b % 256);
            4'd12: r = (a < b) ? a : b;
            4'd13: r = (a < b) ? b : a;
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic ui, input logic [31:0] im, input int lo, input int hi,
                         input logic [31:0] d, input string req);
        logic [31:0] exp;
        @(negedge clk);
        in_valid = 1'b1; op = o; src1 = a; src2 = b; use_imm = ui; imm = im;
        pos_lo = 5'(lo); pos_hi = 5'(hi); dst_old = d;
        exp = ref_calc(o, a, ui ? im : b, lo, hi, d);
        @(negedge clk);
        check(out_valid === 1'b1 && result === exp, req, result, exp);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
            finish_run();
        end
    end

    initial begin
        logic [31:0] pats [8];
        logic [31:0] last;
        pats = '{32'h0, 32'hffff_ffff, 32'h8000_0001, 32'h1234_5678,
                 32'hdead_beef, 32'h7fff_ffff, 32'h0000_00ff, 32'ha5a5_5a5a};
        rst_n = 1'b0; in_valid = 1'b0; op = '0; src1 = '0; src2 = '0;
        use_imm = 1'b0; imm = '0; pos_lo = '0; pos_hi = '0; dst_old = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(out_valid === 1'b0, "R1", {31'd0, out_valid}, 32'd0);
        check(result === 32'd0, "R1", result, 32'd0);
        rst_n = 1'b1;

        // R3 bit-clear
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                apply(4'd0, pats[i], pats[j], 1'b0, 0, 0, 0, 0, "R3");

        // R2 hold and valid drop
        apply(4'd0, 32'hf0f0_f0f0, 32'h00ff_00ff, 1'b0, 0, 0, 0, 0, "R2");
        last = result;
        @(negedge clk);
        check(out_valid === 1'b0, "R2", {31'd0, out_valid}, 32'd0);
        check(result === last, "R2", result, last);

        // R4 run-time bit write, every index and both values
        for (int k = 0; k < 32; k++)
            for (int v = 0; v < 2; v++)
                for (int i = 0; i < 8; i += 3)
                    apply(4'd1, pats[i], 32'((k << 1) | v) | 32'hffff_ffc0, 1'b0, 0, 0, 0, 0, "R4");

        // R5 immediate set/clear
        for (int k = 0; k < 32; k++)
            for (int i = 0; i < 8; i++) begin
                apply(4'd2, pats[i], 0, 1'b0, 0, k, 0, 0, "R5");
                apply(4'd3, pats[i], 0, 1'b0, 0, k, 0, 0, "R5");
            end

        // R6 / R7 all field bounds
        for (int lo = 0; lo < 32; lo++)
            for (int hi = 0; hi < 32; hi++) begin
                apply(4'd4, 32'hdead_beef, 0, 1'b0, 0, lo, hi, 0, "R6");
                apply(4'd5, 32'hffff_ffff, 0, 1'b0, 0, lo, hi, 32'h0100_0010, "R7");
            end
        apply(4'd5, 32'h0000_0005, 0, 1'b0, 0, 4, 7, 32'h0000_00a0, "R7");

        // R8 highest set bit
        apply(4'd6, 0, 32'd0, 1'b0, 0, 0, 0, 0, "R8");
        for (int k = 0; k < 32; k++) begin
            apply(4'd6, 0, 32'd1 << k, 1'b0, 0, 0, 0, 0, "R8");
            apply(4'd6, 0, (32'd1 << k) | 32'd1, 1'b0, 0, 0, 0, 0, "R8");
        end

        // R9 compare codes, R12 unsigned min/max
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) begin
                apply(4'd7,  pats[i], pats[j], 1'b0, 0, 0, 0, 0, "R9");
                apply(4'd12, pats[i], pats[j], 1'b0, 0, 0, 0, 0, "R12");
                apply(4'd13, pats[i], pats[j], 1'b0, 0, 0, 0, 0, "R12");
            end

        // R10 rotate and shifts, upper amount bits set to test masking
        for (int k = 0; k < 32; k++)
            for (int i = 0; i < 8; i++) begin
                apply(4'd8,  pats[i], 32'(k) | 32'hffff_ffe0, 1'b0, 0, 0, 0, 0, "R10");
                apply(4'd9,  pats[i], 32'(k) | 32'h0000_0020, 1'b0, 0, 0, 0, 0, "R10");
                apply(4'd10, pats[i], 32'(k), 1'b0, 0, 0, 0, 0, "R10");
            end

        // R11 multiply
        for (int x = 0; x < 256; x += 5)
            for (int y = 0; y < 256; y += 17)
                apply(4'd11, 32'(x) | 32'hab00_0000, 32'(y) | 32'h0000_ff00, 1'b0, 0, 0, 0, 0, "R11");
        apply(4'd11, 32'hff, 32'hff, 1'b0, 0, 0, 0, 0, "R11");

        // R13 immediate replaces src2
        for (int i = 0; i < 8; i++) begin
            apply(4'd0,  pats[i], 32'hffff_ffff, 1'b1, pats[7 - i], 0, 0, 0, "R13");
            apply(4'd13, pats[i], 32'hffff_ffff, 1'b1, pats[7 - i], 0, 0, 0, "R13");
            apply(4'd9,  pats[i], 32'd0, 1'b1, 32'd7, 0, 0, 0, "R13");
        end

        // R14 reserved opcodes
        for (int i = 0; i < 8; i++) begin
            apply(4'd14, pats[i], pats[7 - i], 1'b0, 0, 3, 9, 32'hffff_ffff, "R14");
            apply(4'd15, pats[i], pats[7 - i], 1'b1, 32'h55, 3, 9, 32'hffff_ffff, "R14");
        end

        done = 1'b1;
        finish_run();
    end

endmodule